// File: doc/BRIEF.md
# Converter Result FIFO with Fill Status

This block buffers the results of a sampling converter between the converter's result path and the host-facing output word. Every finished conversion is presented as the falling edge of a busy line together with a 16-bit result and an out-of-range flag. While buffering is selected, each such result is stored as an 18-bit entry: the result, a second copy of its top bit, and the flag. Sixteen entries can be held, and the oldest one is always visible on the output without any request. The host steps through the stored entries with rising edges on a read strobe, and it watches a two-bit fill code.

When buffering is deselected the output simply tracks the most recent result. New results no longer enter the store. Holding both the path select and the read strobe low empties the store. All inputs are sampled on the system clock. Strobe and busy edges are found by comparing each input with its value one clock earlier.

Top module: `sample_out_fifo`

## Requirements
- R1: After reset the store is empty, `fill_stat` is 2'b01, and the output word is all zeros in both path settings.
- R2: With `path_sel` = 0, the output word equals the last completed result one clock after its busy falling edge, and such results are not stored: the store's contents and fill code are unchanged when `path_sel` returns to 1.
- R3: With `path_sel` = 1, every busy falling edge stores one entry whatever the level of `rd_strobe`. When 16 entries are held, an arriving result is dropped and the store keeps its contents.
- R4: When a result arrives at an empty store, it appears on the output one clock after the busy falling edge and stays there until the next read.
- R5: A rising edge of `rd_strobe` while two or more entries are held replaces the output with the next entry in arrival order. The output word is `out_data` = result, `out_msb` = result bit 15, `out_ovr` = flag.
- R6: `fill_stat` codes the entry count as 2'b01 for zero, 2'b00 for one to seven, 2'b10 for eight to fifteen and 2'b11 for sixteen, and it follows a count change by one clock.
- R7: A rising edge of `rd_strobe` that leaves a single entry marks it as taken. The next falling edge of `rd_strobe` empties the store (fill code 2'b01) while the output keeps that last entry. Read edges on an empty store leave the output unchanged.
- R8: While `path_sel` = 0 and `rd_strobe` = 0 together, the store is cleared, and the fill code reads 2'b01 once buffering is selected again.
- R9: A store and a read advance in the same clock leave the entry count unchanged, even when 16 entries are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_busy | input | 1 | High while a conversion runs; its falling edge marks a new result |
| conv_data | input | 16 | Result of the conversion, valid at the busy falling edge |
| conv_ovr | input | 1 | Out-of-range flag of the conversion |
| path_sel | input | 1 | 1 selects the buffered path, 0 the direct path |
| rd_strobe | input | 1 | Host read strobe; rising edges advance, a low level with `path_sel` = 0 clears |
| out_data | output | 16 | Output result |
| out_msb | output | 1 | Second copy of the output result's top bit |
| out_ovr | output | 1 | Out-of-range flag of the output result |
| fill_stat | output | 2 | Fill code {high bit, low bit} |

## Verification
On every clock the assertions check several things. The count stays within sixteen. A full store keeps its count when a result arrives with no read. The clear combination empties the store. Direct-path conversions never change the count. The direct output tracks the last result. An empty buffered store holds its output. The fill code reads empty or full one clock after those counts. Only the bench scenarios show the arrival order through a wrap of the storage, the deferred empty report on the strobe's falling edge, the combined store-and-advance at full, and that stored entries survive a period on the direct path.

// File: rtl/sfifo_pkg.sv
// Shared types for the converter result FIFO.
// Assumes a single result width for the whole block.
package sfifo_pkg;

    localparam int SAMPLE_W = 16;

    // One stored entry: flag, duplicated top bit, result.
    typedef struct packed {
        logic                ovr;
        logic                msb;
        logic [SAMPLE_W-1:0] data;
    } entry_t;

    // Fill codes, ordered {high bit, low bit}.
    typedef enum logic [1:0] {
        FILL_PART  = 2'b00,
        FILL_EMPTY = 2'b01,
        FILL_HALF  = 2'b10,
        FILL_FULL  = 2'b11
    } fill_code_e;

endpackage

// File: rtl/sfifo_edge.sv
// Single-edge detector on the system clock.
// RISING selects which edge is reported; IDLE is the level assumed at reset.
// Assumes the input is already synchronous to clk.
module sfifo_edge #(
    parameter bit RISING = 1'b1,
    parameter bit IDLE   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic hit
);

    logic prev_q;

    // Remember the input level of the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= sig;
    end

    generate
        if (RISING) begin : g_rise
            assign hit = sig & ~prev_q;
        end else begin : g_fall
            assign hit = ~sig & prev_q;
        end
    endgenerate

endmodule

// File: rtl/sfifo_core.sv
// Storage, pointers and entry count of the result FIFO.
// The head entry is shown combinationally; when the store is empty a
// hold register keeps the last released entry on the output.
// Assumes DEPTH is a power of two and clr never coincides with fifo_on.
module sfifo_core
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_on,
    input  logic          clr,
    input  logic          push,
    input  entry_t        wr_word,
    input  logic          adv_rise,
    input  logic          adv_fall,
    output entry_t        head,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] ONE_C  = CW'(1);
    localparam logic [CW-1:0] TWO_C  = CW'(2);

    entry_t          mem_q [DEPTH];
    entry_t          hold_q;
    logic [AW-1:0]   wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]   cnt_q;
    logic            pend_q;
    logic            do_pop, do_push, do_drain, do_take;

    assign do_pop   = fifo_on & adv_rise & (cnt_q >= TWO_C);
    assign do_push  = fifo_on & push & ((cnt_q != FULL_C) | do_pop);
    assign do_drain = fifo_on & adv_fall & pend_q & (cnt_q == ONE_C);
    assign do_take  = do_pop | do_drain;

    // Write the arriving entry into its slot.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= wr_word;
    end

    // Advance write and read pointers, or rewind both on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_q + AW'(1);
            if (do_take) rd_ptr_q <= rd_ptr_q + AW'(1);
        end
    end

    // Track the number of entries held.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else begin
            case ({do_push, do_take})
                2'b10:   cnt_q <= cnt_q + ONE_C;
                2'b01:   cnt_q <= cnt_q - ONE_C;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Mark the last entry as taken until the strobe falls.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                                    pend_q <= 1'b0;
        else if (fifo_on && adv_fall)                         pend_q <= 1'b0;
        else if (do_pop && cnt_q == TWO_C)                    pend_q <= 1'b1;
        else if (fifo_on && adv_rise && cnt_q == ONE_C)       pend_q <= 1'b1;
    end

    // Keep the released entry visible once the store is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= '0;
        else if (do_drain) hold_q <= mem_q[rd_ptr_q];
    end

    assign head = (cnt_q != '0) ? mem_q[rd_ptr_q] : hold_q;
    assign cnt  = cnt_q;

endmodule

// File: rtl/sfifo_status.sv
// Registered fill-code encoder.
// Assumes cnt never exceeds DEPTH; the code lags the count by one clock.
module sfifo_status
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    output logic [1:0]    code
);

    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

    fill_code_e next_code, code_q;

    // Classify the current count.
    always_comb begin
        if (cnt == '0)          next_code = FILL_EMPTY;
        else if (cnt == FULL_C) next_code = FILL_FULL;
        else if (cnt >= HALF_C) next_code = FILL_HALF;
        else                    next_code = FILL_PART;
    end

    // Register the code for a glitch-free output.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= FILL_EMPTY;
        else        code_q <= next_code;
    end

    assign code = code_q;

endmodule

// File: rtl/sample_out_fifo.sv
// Top of the converter result FIFO: edge detection, direct-path latch,
// buffered store and fill-code output.
// Assumes all inputs are synchronous to clk and the read strobe idles low.
module sample_out_fifo
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_busy,
    input  logic [SAMPLE_W-1:0] conv_data,
    input  logic                conv_ovr,
    input  logic                path_sel,
    input  logic                rd_strobe,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_msb,
    output logic                out_ovr,
    output logic [1:0]          fill_stat
);

    localparam int CW = $clog2(DEPTH) + 1;

    logic          conv_done, rd_rise, rd_fall, clr;
    logic [CW-1:0] cnt_w;
    entry_t        new_word, head_w, latest_q, shown;

    sfifo_edge #(.RISING(1'b0), .IDLE(1'b0)) u_busy_edge (
        .clk(clk), .rst_n(rst_n), .sig(conv_busy), .hit(conv_done)
    );
    sfifo_edge #(.RISING(1'b1), .IDLE(1'b0)) u_rd_rise (
        .clk(clk), .rst_n(rst_n), .sig(rd_strobe), .hit(rd_rise)
    );
    sfifo_edge #(.RISING(1'b0), .IDLE(1'b0)) u_rd_fall (
        .clk(clk), .rst_n(rst_n), .sig(rd_strobe), .hit(rd_fall)
    );

    assign new_word = '{ovr: conv_ovr, msb: conv_data[SAMPLE_W-1], data: conv_data};
    assign clr      = ~path_sel & ~rd_strobe;

    // Latch every finished result for the direct path.
    always_ff @(posedge clk) begin
        if (!rst_n)         latest_q <= '0;
        else if (conv_done) latest_q <= new_word;
    end

    sfifo_core #(.DEPTH(DEPTH)) u_core (
        .clk(clk), .rst_n(rst_n), .fifo_on(path_sel), .clr(clr),
        .push(conv_done), .wr_word(new_word),
        .adv_rise(rd_rise), .adv_fall(rd_fall),
        .head(head_w), .cnt(cnt_w)
    );

    sfifo_status #(.DEPTH(DEPTH)) u_stat (
        .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .code(fill_stat)
    );

    assign shown    = path_sel ? head_w : latest_q;
    assign out_data = shown.data;
    assign out_msb  = shown.msb;
    assign out_ovr  = shown.ovr;

endmodule

// File: rtl/sfifo_chk.sv
// Property checker for sample_out_fifo, attached by bind below.
// Assumes the internal count and completion strobe are passed in.
module sfifo_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          path_sel,
    input logic          rd_strobe,
    input logic          conv_done,
    input logic [15:0]   conv_data,
    input logic          conv_ovr,
    input logic [CW-1:0] cnt,
    input logic [15:0]   out_data,
    input logic          out_ovr,
    input logic [1:0]    fill_stat
);

    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_C);

    // R2
    direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!path_sel && conv_done) |=>
        (path_sel || (out_data == $past(conv_data) && out_ovr == $past(conv_ovr))));

    // R2
    direct_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!path_sel && rd_strobe) |=> $stable(cnt));

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (path_sel && cnt == FULL_C && conv_done && !rd_strobe) |=> cnt == FULL_C);

    // R6
    stat_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> fill_stat == 2'b01);

    // R6
    stat_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL_C) |=> fill_stat == 2'b11);

    // R7
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (path_sel && cnt == '0 && !conv_done) |=>
        (!path_sel || ($stable(out_data) && $stable(out_ovr))));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!path_sel && !rd_strobe) |=> cnt == '0);

endmodule

bind sample_out_fifo sfifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .path_sel(path_sel), .rd_strobe(rd_strobe),
    .conv_done(conv_done), .conv_data(conv_data), .conv_ovr(conv_ovr),
    .cnt(cnt_w), .out_data(out_data), .out_ovr(out_ovr), .fill_stat(fill_stat)
);

// File: tb/tb_sample_out_fifo.sv
// Scoreboard bench: driver tasks update an expected queue, checks compare
// the output word and fill code against its head after each action.
module tb_sample_out_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_busy = 1'b0;
    logic [15:0] conv_data = '0;
    logic        conv_ovr = 1'b0;
    logic        path_sel = 1'b1;
    logic        rd_strobe = 1'b0;
    logic [15:0] out_data;
    logic        out_msb, out_ovr;
    logic [1:0]  fill_stat;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [17:0] exp_q[$];
    logic [17:0] last_w   = '0;
    logic [17:0] latest_w = '0;
    bit          pend     = 1'b0;

    always #2.5 clk = ~clk;

    sample_out_fifo dut (
        .clk(clk), .rst_n(rst_n), .conv_busy(conv_busy), .conv_data(conv_data),
        .conv_ovr(conv_ovr), .path_sel(path_sel), .rd_strobe(rd_strobe),
        .out_data(out_data), .out_msb(out_msb), .out_ovr(out_ovr),
        .fill_stat(fill_stat)
    );

    function automatic logic [15:0] sample_of(input int i);
        return 16'(i * 4099 + 7);
    endfunction

    function automatic logic [17:0] entry_of(input int i);
        logic [15:0] d = sample_of(i);
        return {i[0], d[15], d};
    endfunction

    function automatic logic [1:0] code_of(input int n);
        if (n == 0)  return 2'b01;
        if (n == 16) return 2'b11;
        if (n >= 8)  return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [17:0] exp_out();
        if (!path_sel)        return latest_w;
        if (exp_q.size() > 0) return exp_q[0];
        return last_w;
    endfunction

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic model_rise();
        if (exp_q.size() >= 2) void'(exp_q.pop_front());
        if (exp_q.size() == 1) pend = 1'b1;
    endtask

    task automatic model_fall();
        if (pend && exp_q.size() == 1) last_w = exp_q.pop_front();
        pend = 1'b0;
    endtask

    task automatic model_clear();
        exp_q.delete();
        pend = 1'b0;
    endtask

    task automatic check(input string tag);
        logic [17:0] got = {out_ovr, out_msb, out_data};
        logic [17:0] want = exp_out();
        logic [1:0]  wst = code_of(exp_q.size());
        checks++;
        if (got !== want || (path_sel && fill_stat !== wst)) begin
            errors++;
            $display("FAIL %s: word %h stat %b, expected word %h stat %b",
                     tag, got, fill_stat, want, wst);
        end
    endtask

    task automatic set_rd(input logic v);
        @(negedge clk);
        if (path_sel && v && !rd_strobe) model_rise();
        if (path_sel && !v && rd_strobe) model_fall();
        rd_strobe = v;
        if (!path_sel && !v) model_clear();
        settle();
    endtask

    task automatic set_mode(input logic v);
        @(negedge clk);
        path_sel = v;
        if (!v && !rd_strobe) model_clear();
        settle();
    endtask

    // Finish one conversion; with_read also raises the strobe in that clock.
    task automatic convert(input int i, input bit with_read);
        @(negedge clk);
        conv_busy = 1'b1;
        @(negedge clk);
        @(negedge clk);
        conv_data = sample_of(i);
        conv_ovr  = i[0];
        conv_busy = 1'b0;
        if (with_read) begin
            if (path_sel && !rd_strobe) model_rise();
            rd_strobe = 1'b1;
        end
        latest_w = entry_of(i);
        if (path_sel && exp_q.size() < 16) exp_q.push_back(entry_of(i));
        settle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        check("R1 reset buffered");
        set_mode(1'b0);
        check("R1 reset direct");
        set_mode(1'b1);

        convert(0, 1'b0);
        check("R4 first entry falls through");
        convert(100, 1'b0);
        void'(exp_q.pop_back());
        exp_q.push_back(entry_of(100));
        check("R4 head kept after second store");
        for (int i = 2; i < 8; i++) convert(i, 1'b0);
        check("R6 eight entries");
        for (int i = 8; i < 16; i++) convert(i, 1'b0);
        check("R3 sixteen entries full");
        convert(16, 1'b0);
        check("R3 write at full dropped");

        convert(17, 1'b1);
        check("R9 store and advance at full");
        set_rd(1'b0);
        check("R9 count after strobe falls");

        for (int k = 0; k < 15; k++) begin
            set_rd(1'b1);
            check("R5 advance to next entry");
            set_rd(1'b0);
            check("R6 fill code while draining");
        end
        check("R7 empty after last release");
        set_rd(1'b1);
        check("R7 read on empty keeps word");
        set_rd(1'b0);
        check("R7 strobe fall on empty");

        for (int i = 30; i < 33; i++) convert(i, 1'b0);
        set_rd(1'b1);
        check("R5 advance after refill");
        set_mode(1'b0);
        convert(40, 1'b0);
        check("R2 direct shows latest");
        convert(41, 1'b0);
        check("R2 direct shows newer");
        set_mode(1'b1);
        check("R2 stored entries untouched");

        set_mode(1'b0);
        set_rd(1'b0);
        set_mode(1'b1);
        check("R8 cleared to empty");
        convert(50, 1'b0);
        check("R4 fall-through after clear");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule